// File: doc/BRIEF.md
# SIMD Register Swap Execution Unit

This unit decodes one vector-exchange instruction word and carries it out against its own 32-entry, 64-bit SIMD register file. The caller presents a 32-bit instruction word together with a select that says which encoding applies. One setting selects the fixed-width 32-bit form. The other selects the compact form, which is written as two 16-bit halves. The caller then pulses `start`. The unit checks the fixed opcode bits and rejects malformed but recognisable encodings as undefined. For a legal word it exchanges either one 64-bit register or an adjacent pair of 64-bit registers between the destination index and the source index.

Every accepted operation takes the same number of cycles, whatever the register contents and whatever the outcome of the decode. The unit then raises a one-cycle completion pulse. In that same cycle it reports whether the word was undefined or was not this instruction at all. A debug port reads any register combinationally and writes a register while the unit is idle, so software or a bench can seed and inspect the file.

Top module: `swap_unit`

## Requirements
- R1: After reset every register reads as zero through the debug port, and `done`, `undefFlag` and `notInstrFlag` are low.
- R2: With `compactMode`=0 the word is recognised only if bits 31..23 = 111100111, bits 21..20 = 11, bits 17..16 = 10, bits 11..7 = 00000 and bit 4 = 0. Any other word raises `notInstrFlag` with `done`, and no register changes.
- R3: With `compactMode`=1 the leading nine bits must be 111111111 instead of 111100111, and every other field keeps the same position. A compact word presented with `compactMode`=0, or the reverse, is not this instruction.
- R4: The destination index is {bit 22, bits 15..12} and the source index is {bit 5, bits 3..0}. Each index is 5 bits wide, so registers 0 to 31 can be selected.
- R5: A recognised word whose bits 19..18 are not 00 raises `undefFlag` with `done`, and no register changes.
- R6: A recognised word with bit 6 (pair select) = 1 and bit 12 or bit 0 = 1 raises `undefFlag` with `done`, and no register changes.
- R7: A legal word with bit 6 = 0 exchanges the destination register with the source register, and all other registers keep their values.
- R8: A legal word with bit 6 = 1 exchanges registers d and d+1 with m and m+1 respectively. Each written value is the content from before the operation.
- R9: `done` is high exactly in the third cycle after the clock edge that accepts `start`, and it stays high for one cycle only. `undefFlag` and `notInstrFlag` are high only while `done` is high, and the latency does not depend on the data or on the decode outcome.
- R10: A `start` pulse that arrives while an operation is in progress is ignored.
- R11: When the destination index equals the source index the contents stay the same, and `done` is still asserted with both flags low.
- R12: `undefFlag` and `notInstrFlag` are never high together. A word that fails the fixed-bit check reports only `notInstrFlag`, even when its size field is nonzero.
- R13: A debug write changes the addressed register only while the unit is idle. A debug write that arrives during an operation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation on `instrWord` (accepted when idle) |
| compactMode | input | 1 | 0 = 32-bit fixed form, 1 = compact 16+16 form |
| instrWord | input | 32 | Instruction word to decode |
| done | output | 1 | One-cycle completion pulse |
| undefFlag | output | 1 | Recognised but undefined encoding, valid with `done` |
| notInstrFlag | output | 1 | Fixed opcode bits mismatch, valid with `done` |
| dbgAddr | input | 5 | Debug register index for reads and writes |
| dbgWrEn | input | 1 | Debug write enable (idle only) |
| dbgWrData | input | 64 | Debug write data |
| dbgRdData | output | 64 | Combinational read of register `dbgAddr` |

## Verification
The assertions assume that `start` is a clean synchronous level sampled on the rising edge. They also assume that `instrWord` and `compactMode` are stable at the edge where `start` is accepted, because the word is captured only then. The latency property keeps its own shadow count of accepted starts and assumes nothing else drives the control. The bench changes all inputs only on falling edges, and it performs debug writes only before an operation is started, except for the one deliberate write during a busy cycle.

// File: rtl/swap_pkg.sv
package swap_pkg;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic latchInstr;  // capture instruction word and mode
    logic readPair;    // snapshot both operand pairs
    logic writePair;   // commit the exchange
    logic idle;        // debug writes permitted
  } swapStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } swapState_t;

  localparam int INSTR_W = 32;
  localparam logic [8:0] LEAD_WIDE    = 9'b111100111;
  localparam logic [8:0] LEAD_COMPACT = 9'b111111111;

endpackage

// File: rtl/swap_decode.sv
module swap_decode
  import swap_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               compactMode,
  output logic [IDX_W-1:0]   dIdx,
  output logic [IDX_W-1:0]   mIdx,
  output logic               pairMode,
  output logic               legal,
  output logic               undefEnc,
  output logic               notThis
);

  logic [8:0] leadExpect;
  logic       fixedOk;
  logic       sizeBad;
  logic       oddBad;

  always_comb begin
    leadExpect = compactMode ? LEAD_COMPACT : LEAD_WIDE;
    fixedOk = (instrWord[31:23] == leadExpect) &&
              (instrWord[21:20] == 2'b11) &&
              (instrWord[17:16] == 2'b10) &&
              (instrWord[11:7]  == 5'b00000) &&
              (instrWord[4]     == 1'b0);
    pairMode = instrWord[6];
    sizeBad  = (instrWord[19:18] != 2'b00);
    oddBad   = pairMode && (instrWord[12] || instrWord[0]);
    dIdx     = {instrWord[22], instrWord[15:12]};
    mIdx     = {instrWord[5],  instrWord[3:0]};
    notThis  = !fixedOk;
    undefEnc = fixedOk && (sizeBad || oddBad);
    legal    = fixedOk && !sizeBad && !oddBad;
  end

endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        decLegal,
  input  logic        decUndef,
  input  logic        decNotThis,
  output swapStrobe_t strobe,
  output logic        done,
  output logic        undefFlag,
  output logic        notInstrFlag
);

  swapState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.idle = 1'b1;
        if (start) begin
          strobe.latchInstr = 1'b1;
          stateNext         = ST_READ;
        end
      end
      ST_READ: begin
        strobe.readPair = 1'b1;
        stateNext       = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.writePair = decLegal;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      done         <= 1'b0;
      undefFlag    <= 1'b0;
      notInstrFlag <= 1'b0;
    end else begin
      state        <= stateNext;
      done         <= (state == ST_WRITE);
      undefFlag    <= (state == ST_WRITE) && decUndef;
      notInstrFlag <= (state == ST_WRITE) && decNotThis;
    end
  end

endmodule

// File: rtl/swap_datapath.sv
module swap_datapath
  import swap_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int DATA_W    = 64,
  parameter int IDX_W     = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  swapStrobe_t        strobe,
  input  logic [INSTR_W-1:0] instrIn,
  input  logic               compactIn,
  output logic [INSTR_W-1:0] instrQ,
  output logic               compactQ,
  input  logic [IDX_W-1:0]   dIdx,
  input  logic [IDX_W-1:0]   mIdx,
  input  logic               pairMode,
  input  logic [IDX_W-1:0]   dbgAddr,
  input  logic               dbgWrEn,
  input  logic [DATA_W-1:0]  dbgWrData,
  output logic [DATA_W-1:0]  dbgRdData
);

  localparam logic [IDX_W-1:0] IDX_ONE = 1;

  logic [DATA_W-1:0] regFile [REG_COUNT];
  logic [DATA_W-1:0] holdD0, holdD1, holdM0, holdM1;
  logic [IDX_W-1:0]  dNext, mNext;

  assign dNext     = dIdx + IDX_ONE;
  assign mNext     = mIdx + IDX_ONE;
  assign dbgRdData = regFile[dbgAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ   <= '0;
      compactQ <= 1'b0;
    end else if (strobe.latchInstr) begin
      instrQ   <= instrIn;
      compactQ <= compactIn;
    end
  end

  // Operand snapshot: both pairs read together so writes see old values.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdD0 <= '0;
      holdD1 <= '0;
      holdM0 <= '0;
      holdM1 <= '0;
    end else if (strobe.readPair) begin
      holdD0 <= regFile[dIdx];
      holdD1 <= regFile[dNext];
      holdM0 <= regFile[mIdx];
      holdM1 <= regFile[mNext];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (strobe.writePair) begin
      regFile[dIdx] <= holdM0;
      regFile[mIdx] <= holdD0;
      if (pairMode) begin
        regFile[dNext] <= holdM1;
        regFile[mNext] <= holdD1;
      end
    end else if (dbgWrEn && strobe.idle) begin
      regFile[dbgAddr] <= dbgWrData;
    end
  end

endmodule

// File: rtl/swap_unit.sv
module swap_unit
  import swap_pkg::*;
#(
  parameter int REG_COUNT = 32,
  parameter int DATA_W    = 64,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              compactMode,
  input  logic [31:0]       instrWord,
  output logic              done,
  output logic              undefFlag,
  output logic              notInstrFlag,
  input  logic [IDX_W-1:0]  dbgAddr,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData
);

  swapStrobe_t        strobe;
  logic [INSTR_W-1:0] instrQ;
  logic               compactQ;
  logic [IDX_W-1:0]   dIdx, mIdx;
  logic               pairMode, decLegal, decUndef, decNotThis;
  logic               wrStrobe;

  assign wrStrobe = strobe.writePair;

  swap_decode #(.IDX_W(IDX_W)) u_decode (
    .instrWord   (instrQ),
    .compactMode (compactQ),
    .dIdx        (dIdx),
    .mIdx        (mIdx),
    .pairMode    (pairMode),
    .legal       (decLegal),
    .undefEnc    (decUndef),
    .notThis     (decNotThis)
  );

  swap_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .decLegal     (decLegal),
    .decUndef     (decUndef),
    .decNotThis   (decNotThis),
    .strobe       (strobe),
    .done         (done),
    .undefFlag    (undefFlag),
    .notInstrFlag (notInstrFlag)
  );

  swap_datapath #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instrIn   (instrWord),
    .compactIn (compactMode),
    .instrQ    (instrQ),
    .compactQ  (compactQ),
    .dIdx      (dIdx),
    .mIdx      (mIdx),
    .pairMode  (pairMode),
    .dbgAddr   (dbgAddr),
    .dbgWrEn   (dbgWrEn),
    .dbgWrData (dbgWrData),
    .dbgRdData (dbgRdData)
  );

endmodule

// File: rtl/swap_unit_chk.sv
module swap_unit_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic done,
  input logic undefFlag,
  input logic notInstrFlag,
  input logic wrStrobe,
  input logic decLegal
);

  // Shadow count of an accepted operation: 1,2,3 while in flight.
  logic [1:0] shadowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) shadowCnt <= 2'd0;
    else if ((shadowCnt == 2'd0 || shadowCnt == 2'd3) && start) shadowCnt <= 2'd1;
    else if (shadowCnt == 2'd3) shadowCnt <= 2'd0;
    else if (shadowCnt != 2'd0) shadowCnt <= shadowCnt + 2'd1;
  end

  p_fixed_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    done == (shadowCnt == 2'd3));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_flags_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (undefFlag || notInstrFlag) |-> done);

  p_flags_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(undefFlag && notInstrFlag));

  p_write_only_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> decLegal);

  p_no_write_before_undef_r6: assert property (@(posedge clk) disable iff (!rstN)
    (undefFlag || notInstrFlag) |-> !$past(wrStrobe));

endmodule

bind swap_unit swap_unit_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .done         (done),
  .undefFlag    (undefFlag),
  .notInstrFlag (notInstrFlag),
  .wrStrobe     (wrStrobe),
  .decLegal     (decLegal)
);

// File: tb/swap_unit_tb.sv
module swap_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        compactMode = 1'b0;
  logic [31:0] instrWord = '0;
  logic        done, undefFlag, notInstrFlag;
  logic [4:0]  dbgAddr = '0;
  logic        dbgWrEn = 1'b0;
  logic [63:0] dbgWrData = '0;
  logic [63:0] dbgRdData;

  int total = 0;
  int bad = 0;
  logic [63:0] model [32];

  always #5 clk = ~clk;

  swap_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .compactMode(compactMode),
    .instrWord(instrWord), .done(done), .undefFlag(undefFlag),
    .notInstrFlag(notInstrFlag), .dbgAddr(dbgAddr), .dbgWrEn(dbgWrEn),
    .dbgWrData(dbgWrData), .dbgRdData(dbgRdData)
  );

  // Build a word: lead bits chosen by cm, then fields per R2/R4/R5.
  function automatic logic [31:0] mk(input logic cm, input logic [4:0] d,
                                     input logic [4:0] m, input logic q,
                                     input logic [1:0] sz);
    logic [8:0] lead;
    lead = cm ? 9'b111111111 : 9'b111100111;
    return {lead, d[4], 2'b11, sz, 2'b10, d[3:0], 5'b00000, q, m[4], 1'b0, m[3:0]};
  endfunction

  // Vector: {expKind[1:0], compactMode, word}; expKind 0=ok 1=undef 2=notThis
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 1'b0, mk(0, 5'd3,  5'd17, 0, 2'b00)},
    {2'd0, 1'b1, mk(1, 5'd20, 5'd5,  0, 2'b00)},
    {2'd0, 1'b0, mk(0, 5'd2,  5'd30, 1, 2'b00)},
    {2'd0, 1'b1, mk(1, 5'd16, 5'd8,  1, 2'b00)},
    {2'd1, 1'b0, mk(0, 5'd1,  5'd2,  0, 2'b01)},
    {2'd1, 1'b1, mk(1, 5'd9,  5'd10, 0, 2'b10)},
    {2'd1, 1'b0, mk(0, 5'd3,  5'd4,  1, 2'b00)},
    {2'd1, 1'b0, mk(0, 5'd4,  5'd9,  1, 2'b00)},
    {2'd0, 1'b0, mk(0, 5'd7,  5'd7,  0, 2'b00)},
    {2'd0, 1'b1, mk(1, 5'd12, 5'd12, 1, 2'b00)},
    {2'd2, 1'b0, mk(1, 5'd3,  5'd4,  0, 2'b00)},
    {2'd2, 1'b1, mk(0, 5'd3,  5'd4,  0, 2'b00)},
    {2'd2, 1'b0, mk(0, 5'd3,  5'd4,  0, 2'b00) | 32'h10},
    {2'd2, 1'b0, mk(0, 5'd3,  5'd4,  0, 2'b00) | 32'h100},
    {2'd0, 1'b0, mk(0, 5'd31, 5'd0,  0, 2'b00)},
    {2'd2, 1'b0, mk(0, 5'd5,  5'd6,  0, 2'b01) | 32'h10}
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 14:  return "R7 R4";
      1:      return "R3 R7";
      2, 3:   return "R8 R4";
      4, 5:   return "R5";
      6, 7:   return "R6";
      8, 9:   return "R11";
      10, 11: return "R3";
      15:     return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyModel(input logic [31:0] w);
    logic [4:0] d, m;
    logic [63:0] t;
    d = {w[22], w[15:12]};
    m = {w[5], w[3:0]};
    t = model[d]; model[d] = model[m]; model[m] = t;
    if (w[6]) begin
      t = model[d+5'd1]; model[d+5'd1] = model[m+5'd1]; model[m+5'd1] = t;
    end
  endtask

  task automatic checkFile(input string req);
    int badIdx = -1;
    logic [63:0] act = '0, exp = '0;
    for (int i = 0; i < 32; i++) begin
      dbgAddr = 5'(i);
      #1;
      if (badIdx < 0 && dbgRdData !== model[i]) begin
        badIdx = i; act = dbgRdData; exp = model[i];
      end
    end
    chk(badIdx < 0, req, act, exp);
  endtask

  task automatic runOp(input logic cm, input logic [31:0] w, input int kind,
                       input string tag);
    logic [2:0] seen;
    @(negedge clk);
    start = 1'b1; compactMode = cm; instrWord = w;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    seen[0] = done;
    @(posedge clk); @(negedge clk);
    seen[1] = done;
    @(posedge clk); @(negedge clk);
    seen[2] = done;
    chk(seen == 3'b100, {tag, " R9 latency"}, 64'(seen), 64'b100);
    chk({undefFlag, notInstrFlag} == {kind == 1, kind == 2}, {tag, " flags"},
        64'({undefFlag, notInstrFlag}), 64'({kind == 1, kind == 2}));
    @(posedge clk); @(negedge clk);
    chk(!done && !undefFlag && !notInstrFlag, {tag, " R9 pulse"},
        64'({done, undefFlag, notInstrFlag}), 64'd0);
    if (kind == 0) applyModel(w);
    checkFile({tag, " contents"});
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk(!done && !undefFlag && !notInstrFlag, "R1 outputs", 64'({done, undefFlag, notInstrFlag}), 64'd0);
    checkFile("R1 registers zero");

    // Seed the file through the debug port (R13, idle writes).
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      model[i] = {8'(i), 24'hC0FFEE, 32'(i) * 32'h9E3779B9};
      dbgAddr = 5'(i); dbgWrEn = 1'b1; dbgWrData = model[i];
    end
    @(negedge clk);
    dbgWrEn = 1'b0;
    checkFile("R13 idle debug write");

    for (int v = 0; v < NV; v++)
      runOp(VEC[v][32], VEC[v][31:0], int'(VEC[v][34:33]), vecTag(v));

    // R10 / R13: start and debug write while busy are dropped.
    begin
      logic [3:0] seenDone;
      @(negedge clk);
      start = 1'b1; compactMode = 1'b0; instrWord = mk(0, 5'd6, 5'd11, 0, 2'b00);
      @(posedge clk); @(negedge clk);
      instrWord = mk(0, 5'd25, 5'd26, 0, 2'b00);
      dbgAddr = 5'd27; dbgWrEn = 1'b1; dbgWrData = 64'hDEAD_BEEF_0000_0001;
      @(posedge clk); @(negedge clk);
      start = 1'b0; dbgWrEn = 1'b0;
      @(posedge clk); @(negedge clk);
      seenDone[0] = done;
      for (int k = 1; k < 4; k++) begin
        @(posedge clk); @(negedge clk);
        seenDone[k] = done;
      end
      chk(seenDone == 4'b0001, "R10 single done", 64'(seenDone), 64'b0001);
      applyModel(mk(0, 5'd6, 5'd11, 0, 2'b00));
      checkFile("R10 R13 busy inputs dropped");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule